// File: doc/BRIEF.md
# Addressed Serial Control-Word Loader

This block is the receive side of a three-wire configuration port for a frequency synthesizer. A host drives a serial clock, a data line and a latch strobe. Data bits enter a 24-bit input register, most significant bit first, on each rising edge of the serial clock. When the latch strobe rises, the complete word is copied into one of four held configuration registers. The two least significant bits of the word select the register.

The four destinations are as follows:
- the reference-divider word
- the feedback-divider word
- the function word
- the initialization word

The function and initialization words share one field layout and differ only in their address code. The block also decodes the divider fields from the held words: the reference count, the A and B counts, and the gain option bit.

The serial pins are asynchronous to the system clock. They are synchronized and edge-detected inside the block. A chip-enable input freezes the port while it is low. Each latch produces a one-cycle strobe for the register that was written. A latch that follows any bit count other than 24 raises a framing flag, and the load still takes place.

Top module: `cwl_loader`

## Requirements
- R1: After reset, all four held registers, all decoded fields, the update strobe and the framing flag are zero.
- R2: While chip enable is high, each rising serial-clock edge shifts the serial data bit into the input register at bit 0. The earlier bits move toward bit 23, so the first bit sent ends in bit 23 after 24 clocks.
- R3: A rising edge of the latch strobe copies the input register into the destination selected by its bits [1:0]. The codes are: 00 reference, 01 feedback, 10 function, 11 initialization.
- R4: A latch leaves the three unselected registers unchanged.
- R5: `upd_strobe` is one-hot for exactly one system clock per latch. Bit 0 marks reference, bit 1 feedback, bit 2 function and bit 3 initialization.
- R6: `ref_div` equals reference-word bits [15:2]. `fb_a` equals feedback bits [7:2], `fb_b` equals feedback bits [20:8], and `fb_gain` equals feedback bit 21.
- R7: A latch that follows a bit count other than 24 since the previous latch sets `frame_err`, and the load still occurs. A latch that follows exactly 24 bits clears `frame_err`.
- R8: While chip enable is low, serial-clock and latch edges are ignored. The input register, the bit count and the held registers keep their values.
- R9: The bit count restarts at each latch. When more than 24 bits arrive before a latch, the input register holds the last 24 bits received.
- R10: Holding the latch strobe high causes only one load. Only its rising edge acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; rising edge loads |
| chip_en | input | 1 | Port enable; low freezes the port |
| reg_ref | output | 24 | Held reference-divider word |
| reg_fb | output | 24 | Held feedback-divider word |
| reg_func | output | 24 | Held function word |
| reg_init | output | 24 | Held initialization word |
| ref_div | output | 14 | Reference divide count |
| fb_a | output | 6 | Feedback A count |
| fb_b | output | 13 | Feedback B count |
| fb_gain | output | 1 | Feedback gain option bit |
| upd_strobe | output | 4 | One-cycle one-hot load marker |
| frame_err | output | 1 | Last latch followed a bit count other than 24 |

## Verification
The assertions check, on every cycle, several properties of the port:
- the update strobe is never more than one-hot;
- a strobed register holds the word that was offered one cycle earlier;
- an unstrobed register does not move;
- the framing flag matches the count at the latch;
- the bit count never exceeds its saturation limit;
- the input register stays frozen while the port is disabled.

Only the bench scenarios can show the rest. These are the MSB-first ordering across a whole transfer, the choice of destination from the address bits, and the keeping of the last 24 bits of an overlong frame. They also include the single load while the strobe is held high and the decoded field positions. The bench compares each of these against its own model after directed and random transfers.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
   localparam int unsigned ADDR_W   = 2;
   localparam int unsigned NUM_DEST = 1 << ADDR_W;

   typedef enum logic [ADDR_W-1:0] {
      DST_REF  = 2'b00,
      DST_FB   = 2'b01,
      DST_FUNC = 2'b10,
      DST_INIT = 2'b11
   } dest_e;
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
   parameter int unsigned N      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("cwl_sync: STAGES must be at least 1");
   end
   if (N < 1) begin : g_bad_n
      $error("cwl_sync: N must be at least 1");
   end

   logic [N-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cwl_shift.sv
module cwl_shift #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              le_s,
   input  logic              en_s,
   output logic [WORD_W-1:0] word,
   output logic              latch,
   output logic              frame_ok
);
   localparam int unsigned CNT_MAX = WORD_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W < 4) begin : g_bad_word
      $error("cwl_shift: WORD_W too small");
   end

   logic             sclk_q, le_q;
   logic             sclk_rise;
   logic [WORD_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         le_q   <= le_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q & en_s;
   assign latch     = le_s & ~le_q & en_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sh <= '0;
      else if (sclk_rise) sh <= {sh[WORD_W-2:0], sdat_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (latch)                      cnt <= '0;
      else if (sclk_rise && cnt != CNT_SAT) cnt <= cnt + 1'b1;
   end

   assign word     = sh;
   assign frame_ok = (cnt == CNT_FULL);

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_SAT);
   p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> cnt == '0);
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> $stable(sh) && $stable(cnt));
endmodule

// File: rtl/cwl_bank.sv
module cwl_bank
   import cwl_pkg::*;
#(
   parameter int unsigned WORD_W = 24
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             latch,
   input  logic                             frame_ok,
   input  logic [WORD_W-1:0]                word,
   output logic [NUM_DEST-1:0][WORD_W-1:0]  regs,
   output logic [NUM_DEST-1:0]              upd,
   output logic                             frame_err
);
   if (WORD_W <= ADDR_W) begin : g_bad_word
      $error("cwl_bank: word must be wider than the address");
   end

   logic [ADDR_W-1:0] dest;
   assign dest = word[ADDR_W-1:0];

   for (genvar i = 0; i < NUM_DEST; i++) begin : g_dest
      logic hit;
      assign hit = latch && (dest == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
            upd[i]  <= 1'b0;
         end else begin
            upd[i] <= hit;
            if (hit) regs[i] <= word;
         end
      end

      p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
         upd[i] |-> regs[i] == $past(word));
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !upd[i] |-> $stable(regs[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frame_err <= 1'b0;
      else if (latch) frame_err <= ~frame_ok;
   end

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd));
   p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> $countones(upd) == 1);
   p_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> frame_err == !$past(frame_ok));
endmodule

// File: rtl/cwl_loader.sv
module cwl_loader
   import cwl_pkg::*;
#(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REF_LSB     = 2,
   parameter int unsigned REF_W       = 14,
   parameter int unsigned A_LSB       = 2,
   parameter int unsigned A_W         = 6,
   parameter int unsigned B_LSB       = 8,
   parameter int unsigned B_W         = 13,
   parameter int unsigned GAIN_BIT    = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   input  logic              chip_en,
   output logic [WORD_W-1:0] reg_ref,
   output logic [WORD_W-1:0] reg_fb,
   output logic [WORD_W-1:0] reg_func,
   output logic [WORD_W-1:0] reg_init,
   output logic [REF_W-1:0]  ref_div,
   output logic [A_W-1:0]    fb_a,
   output logic [B_W-1:0]    fb_b,
   output logic              fb_gain,
   output logic [NUM_DEST-1:0] upd_strobe,
   output logic              frame_err
);
   if (REF_LSB + REF_W > WORD_W) begin : g_bad_ref
      $error("cwl_loader: reference field exceeds word");
   end
   if (A_LSB + A_W > B_LSB) begin : g_bad_a
      $error("cwl_loader: A field overlaps B field");
   end
   if (B_LSB + B_W > GAIN_BIT + 1 || GAIN_BIT >= WORD_W) begin : g_bad_b
      $error("cwl_loader: B or gain field out of range");
   end
   if (REF_LSB < ADDR_W || A_LSB < ADDR_W) begin : g_bad_addr
      $error("cwl_loader: fields overlap address bits");
   end

   logic [3:0] pins_s;
   logic       sclk_s, sdat_s, le_s, en_s;

   cwl_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({chip_en, ser_le, ser_dat, ser_clk}),
      .q     (pins_s)
   );
   assign {en_s, le_s, sdat_s, sclk_s} = pins_s;

   logic [WORD_W-1:0] word;
   logic              latch, frame_ok;

   cwl_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .sdat_s   (sdat_s),
      .le_s     (le_s),
      .en_s     (en_s),
      .word     (word),
      .latch    (latch),
      .frame_ok (frame_ok)
   );

   logic [NUM_DEST-1:0][WORD_W-1:0] regs;

   cwl_bank #(.WORD_W(WORD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch     (latch),
      .frame_ok  (frame_ok),
      .word      (word),
      .regs      (regs),
      .upd       (upd_strobe),
      .frame_err (frame_err)
   );

   assign reg_ref  = regs[DST_REF];
   assign reg_fb   = regs[DST_FB];
   assign reg_func = regs[DST_FUNC];
   assign reg_init = regs[DST_INIT];

   assign ref_div = reg_ref[REF_LSB +: REF_W];
   assign fb_a    = reg_fb[A_LSB +: A_W];
   assign fb_b    = reg_fb[B_LSB +: B_W];
   assign fb_gain = reg_fb[GAIN_BIT];

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> upd_strobe == '0);
   p_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_strobe[DST_FB] |-> $stable(fb_b) && $stable(fb_a) && $stable(fb_gain));
endmodule

// File: tb/cwl_loader_test.sv
module cwl_loader_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
   logic [23:0] reg_ref, reg_fb, reg_func, reg_init;
   logic [13:0] ref_div;
   logic [5:0]  fb_a;
   logic [12:0] fb_b;
   logic        fb_gain;
   logic [3:0]  upd_strobe;
   logic        frame_err;

   always #4 clk = ~clk;

   cwl_loader uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .chip_en(chip_en), .reg_ref(reg_ref), .reg_fb(reg_fb),
      .reg_func(reg_func), .reg_init(reg_init), .ref_div(ref_div), .fb_a(fb_a),
      .fb_b(fb_b), .fb_gain(fb_gain), .upd_strobe(upd_strobe), .frame_err(frame_err)
   );

   int checks = 0, fails = 0;
   logic [23:0] exp_reg [4];
   logic        exp_ferr = 1'b0;
   logic [23:0] sh_m = '0;
   int          cnt_m = 0;
   int          pcnt [4];
   int          pcnt_snap [4];
   int          multi_hot = 0;

   initial for (int i = 0; i < 4; i++) begin
      pcnt[i] = 0;
      exp_reg[i] = '0;
   end

   always @(negedge clk) if (rst_n) begin
      for (int i = 0; i < 4; i++) if (upd_strobe[i]) pcnt[i]++;
      if ($countones(upd_strobe) > 1) multi_hot++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] mk(input logic [21:0] body, input logic [1:0] a);
      return {body, a};
   endfunction

   task automatic send_bits(input logic [31:0] val, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = val[i];
         ser_clk = 1'b0;
         repeat (4) @(posedge clk);
         ser_clk = 1'b1;
         repeat (4) @(posedge clk);
         ser_clk = 1'b0;
         repeat (4) @(posedge clk);
         if (chip_en) begin
            sh_m = {sh_m[22:0], val[i]};
            cnt_m++;
         end
      end
   endtask

   task automatic do_latch(input int hold);
      for (int i = 0; i < 4; i++) pcnt_snap[i] = pcnt[i];
      ser_le = 1'b1;
      repeat (hold) @(posedge clk);
      ser_le = 1'b0;
      repeat (8) @(posedge clk);
      if (chip_en) begin
         exp_reg[sh_m[1:0]] = sh_m;
         exp_ferr = (cnt_m != 24);
         cnt_m = 0;
      end
   endtask

   task automatic check_all(input logic was_en, input string tag);
      @(negedge clk);
      chk({tag, " R3/R4 ref"},  {8'h0, reg_ref},  {8'h0, exp_reg[0]});
      chk({tag, " R3/R4 fb"},   {8'h0, reg_fb},   {8'h0, exp_reg[1]});
      chk({tag, " R3/R4 func"}, {8'h0, reg_func}, {8'h0, exp_reg[2]});
      chk({tag, " R3/R4 init"}, {8'h0, reg_init}, {8'h0, exp_reg[3]});
      chk({tag, " R6 ref_div"}, {18'h0, ref_div}, {18'h0, exp_reg[0][15:2]});
      chk({tag, " R6 fb_a"},    {26'h0, fb_a},    {26'h0, exp_reg[1][7:2]});
      chk({tag, " R6 fb_b"},    {19'h0, fb_b},    {19'h0, exp_reg[1][20:8]});
      chk({tag, " R6 fb_gain"}, {31'h0, fb_gain}, {31'h0, exp_reg[1][21]});
      chk({tag, " R7 frame_err"}, {31'h0, frame_err}, {31'h0, exp_ferr});
      for (int i = 0; i < 4; i++) begin
         int d = pcnt[i] - pcnt_snap[i];
         int e = (was_en && sh_m[1:0] == i) ? 1 : 0;
         chk({tag, " R5 strobe count"}, d, e);
      end
      chk({tag, " R5 one-hot"}, multi_hot, 0);
   endtask

   task automatic xfer(input logic [23:0] w, input int n, input int hold, input string tag);
      logic was_en;
      was_en = chip_en;
      send_bits({8'h0, w}, n);
      do_latch(hold);
      check_all(was_en, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1F2E3D4C));
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R1 reset upd", {28'h0, upd_strobe}, 0);
      chk("R1 reset ferr", {31'h0, frame_err}, 0);
      chk("R1 reset regs", {8'h0, reg_ref | reg_fb | reg_func | reg_init}, 0);
      chk("R1 reset fields", {18'h0, ref_div} | {26'h0, fb_a} | {19'h0, fb_b}, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R2 R3 directed: each destination, MSB first
      xfer(mk(22'h0A5F1C, 2'b00), 24, 8, "dir ref R2");
      xfer(mk({1'b0, 1'b1, 13'h1ABC, 6'h2D}, 2'b01), 24, 8, "dir fb R2");
      xfer(mk(22'h3C0F0F, 2'b10), 24, 8, "dir func");
      xfer(mk(22'h155555, 2'b11), 24, 8, "dir init");
      chk("R2 msb first", {8'h0, reg_fb}, {8'h0, 2'b00, 1'b1, 13'h1ABC, 6'h2D, 2'b01});
      // R7 short frame
      xfer(24'h00ABC1, 20, 8, "short R7");
      // R9 long frame keeps last 24 bits
      xfer(24'h9876F0, 27, 8, "long R9");
      xfer(mk(22'h2AAAAA, 2'b10), 24, 8, "good clears R7");
      // R10 latch held high long
      xfer(mk(22'h012345, 2'b11), 24, 200, "held R10");
      // R8 disabled transfer and latch
      chip_en = 1'b0;
      repeat (6) @(posedge clk);
      xfer(24'hFFFFFF, 24, 8, "disabled R8");
      chip_en = 1'b1;
      repeat (6) @(posedge clk);
      xfer(mk(22'h0F0F0F, 2'b00), 24, 8, "after enable R8");

      for (int t = 0; t < 50; t++) begin
         logic [23:0] w;
         int n, r;
         w = 24'($urandom);
         r = $urandom_range(0, 9);
         n = (r == 0) ? $urandom_range(8, 23) : (r == 1) ? $urandom_range(25, 30) : 24;
         if (r == 2) begin
            chip_en = 1'b0;
            repeat (6) @(posedge clk);
         end
         xfer(w, n, $urandom_range(6, 20), "random R2");
         if (!chip_en) begin
            chip_en = 1'b1;
            repeat (6) @(posedge clk);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule